// File: doc/BRIEF.md
# Configuration Bit Command Controller

This block owns a small bank of nonvolatile general-purpose configuration bits and lets software change and inspect them through a four-word register window. Software writes a command word that carries a protection key, an opcode and an argument. Set and clear commands take a programmable number of cycles to finish, which stands in for the slow nonvolatile write. A get command takes a snapshot of the bank. Software then collects the snapshot as a stream of 32-bit words from a result register. Completion shows up as a ready flag, which can also drive a level interrupt. A rejected command raises an error flag, and that flag stays set until the status register is read.

Configuration bit 0 is a security lock. While it is set, the block withholds its grants to the debug access port and to the fast programming port. No command can clear it. It drops only when the external erase input has been asserted and the array then reports a completed full erase. The storage is modelled as flops. Array read traffic is not gated by this block, so reads continue while a command is running.

Top module: `cfgbit_ctrl`

## Requirements
- R1: After reset the status reads ready=1 and error=0, all configuration bits are 0, irq is 0, lock is 0, and both access grants are 1.
- R2: A command-register write (offset 1) whose key byte (bits 31:24) differs from KEY (default 8'h5A) while ready sets the error flag (status bit 1). It changes no configuration bit, and ready (status bit 0) stays 1.
- R3: With a matching key, opcode 8'h01 in bits 7:0 sets the configuration bit whose number is in argument bits 23:8, and opcode 8'h02 clears it. The bank is visible on cfg_bits.
- R4: A set or clear whose argument is greater than or equal to NUM_BITS changes no bit but still completes and returns ready to 1.
- R5: Accepting a valid command drops ready. Ready stays low for exactly BUSY_CYCLES cycles on a set or clear, and for exactly one cycle on a get. Command writes made while ready is low are ignored entirely.
- R6: irq is high exactly when ready is 1 and the mode register (offset 0) bit 0 is 1.
- R7: Get (opcode 8'h03) ignores its argument. The next read of the result register (offset 3) returns bits 0..31 with bit n at position n. Each following read returns the next 32 bits, and reads after the last word return 0.
- R8: While configuration bit 0 is 1, lock is 1 and dbg_allow and fprog_allow are 0. A clear command aimed at bit 0 leaves it at 1.
- R9: Bit 0 returns to 0 only when erase_done pulses after erase_pin has been seen high. An erase_done pulse without a prior erase_pin has no effect.
- R10: A read of the status register (offset 2) returns the current error flag and then clears it.
- R11: A key-matched command with an opcode other than 8'h01, 8'h02 or 8'h03 is rejected like a bad key, setting the error flag.
- R12: Result-register reads before any get command return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (applies read side effects) |
| bus_addr | input | 2 | Register word offset: 0 mode, 1 command, 2 status, 3 result |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| erase_pin | input | 1 | External erase request |
| erase_done | input | 1 | Pulse from the array when a full erase has completed |
| irq | output | 1 | Ready interrupt, level |
| lock | output | 1 | Security bit state |
| dbg_allow | output | 1 | Grant for debug-port array access |
| fprog_allow | output | 1 | Grant for fast-programming-port array access |
| cfg_bits | output | NUM_BITS (3) | Current configuration bits |

## Verification
The checker assumes that register strobes arrive only after the internal reset has been released, and that a read and a write never share a cycle. Under those conditions, status reads and command writes cannot collide in one cycle. It also assumes that erase_done arrives as a single-cycle pulse from the array. The bench drives every access from its negedge tasks, one strobe at a time, and starts only after several cycles past reset release. It also observes ready and the error flag through the side-effect-free combinational read path, so that observing them does not clear the error.

// File: rtl/cfgbit_pkg.sv
package cfgbit_pkg;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_CMD    = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_RESULT = 2'd3;

  localparam logic [7:0] OPC_SET = 8'h01;
  localparam logic [7:0] OPC_CLR = 8'h02;
  localparam logic [7:0] OPC_GET = 8'h03;

  typedef struct packed {
    logic [7:0]  key;
    logic [15:0] arg;
    logic [7:0]  opc;
  } cmd_word_t;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_SET,
    KIND_CLR,
    KIND_GET
  } cmd_kind_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_PROG,
    SEQ_GET
  } seq_state_t;

endpackage

// File: rtl/cfgbit_cmd_decode.sv
module cfgbit_cmd_decode
  import cfgbit_pkg::*;
#(
  parameter logic [7:0] KEY      = 8'h5A,
  parameter int         NUM_BITS = 3,
  localparam int        IDX_W    = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic [31:0]      wdata,
  output logic             key_ok,
  output cmd_kind_t        kind,
  output logic             in_range,
  output logic [IDX_W-1:0] bit_idx
);

  cmd_word_t cw;

  always_comb begin
    cw     = cmd_word_t'(wdata);
    key_ok = (cw.key == KEY);
    case (cw.opc)
      OPC_SET: kind = KIND_SET;
      OPC_CLR: kind = KIND_CLR;
      OPC_GET: kind = KIND_GET;
      default: kind = KIND_NONE;
    endcase
    in_range = (cw.arg < 16'(NUM_BITS));
    bit_idx  = cw.arg[IDX_W-1:0];
  end

endmodule

// File: rtl/cfgbit_seq.sv
module cfgbit_seq
  import cfgbit_pkg::*;
#(
  parameter int  NUM_BITS    = 3,
  parameter int  BUSY_CYCLES = 8,
  localparam int IDX_W       = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1,
  localparam int CNT_W       = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             key_ok,
  input  cmd_kind_t        kind,
  input  logic             in_range,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             stat_rd,
  output logic             ready,
  output logic             err,
  output logic             do_set,
  output logic             do_clr,
  output logic [IDX_W-1:0] do_idx,
  output logic             get_done
);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cmd_kind_t        pkind_q, pkind_d;
  logic             prange_q, prange_d;
  logic [IDX_W-1:0] pidx_q, pidx_d;
  logic             err_q, err_d;
  logic             accept, reject, prog_end;

  always_comb begin
    accept   = cmd_wr && (state_q == SEQ_IDLE) && key_ok && (kind != KIND_NONE);
    reject   = cmd_wr && (state_q == SEQ_IDLE) && !(key_ok && (kind != KIND_NONE));
    prog_end = (state_q == SEQ_PROG) && (cnt_q == '0);

    state_d  = state_q;
    cnt_d    = cnt_q;
    pkind_d  = pkind_q;
    prange_d = prange_q;
    pidx_d   = pidx_q;

    case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          pkind_d  = kind;
          prange_d = in_range;
          pidx_d   = bit_idx;
          cnt_d    = CNT_W'(BUSY_CYCLES - 1);
          state_d  = (kind == KIND_GET) ? SEQ_GET : SEQ_PROG;
        end
      end
      SEQ_PROG: begin
        if (prog_end) state_d = SEQ_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      SEQ_GET:  state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase

    if (reject)       err_d = 1'b1;
    else if (stat_rd) err_d = 1'b0;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      pkind_q  <= KIND_NONE;
      prange_q <= 1'b0;
      pidx_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (state_q != SEQ_IDLE || accept) cnt_q <= cnt_d;
      if (accept) begin
        pkind_q  <= pkind_d;
        prange_q <= prange_d;
        pidx_q   <= pidx_d;
      end
    end
  end

  assign ready    = (state_q == SEQ_IDLE);
  assign err      = err_q;
  assign do_set   = prog_end && (pkind_q == KIND_SET) && prange_q;
  assign do_clr   = prog_end && (pkind_q == KIND_CLR) && prange_q;
  assign do_idx   = pidx_q;
  assign get_done = (state_q == SEQ_GET);

endmodule

// File: rtl/cfgbit_store.sv
module cfgbit_store #(
  parameter int  NUM_BITS = 3,
  localparam int IDX_W    = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                do_set,
  input  logic                do_clr,
  input  logic [IDX_W-1:0]    do_idx,
  input  logic                erase_pin,
  input  logic                erase_done,
  output logic [NUM_BITS-1:0] bits
);

  logic armed_q, armed_d, wipe;

  always_comb begin
    wipe    = erase_done && (armed_q || erase_pin);
    armed_d = armed_q;
    if (erase_pin) armed_d = 1'b1;
    else if (wipe) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  for (genvar g = 0; g < NUM_BITS; g++) begin : g_bit
    logic q, d, hit;
    always_comb begin
      hit = (do_idx == IDX_W'(g));
      d   = q;
      if (do_set && hit) d = 1'b1;
      if (g != 0) begin
        if (do_clr && hit) d = 1'b0;
      end else begin
        if (wipe) d = 1'b0;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign bits[g] = q;
  end

endmodule

// File: rtl/cfgbit_result.sv
module cfgbit_result #(
  parameter int  NUM_BITS  = 3,
  localparam int NUM_WORDS = (NUM_BITS + 31) / 32,
  localparam int WIDX_W    = $clog2(NUM_WORDS + 1),
  localparam int PAD_W     = NUM_WORDS * 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                get_done,
  input  logic [NUM_BITS-1:0] bits,
  input  logic                pop,
  output logic [31:0]         word
);

  logic [PAD_W-1:0]  snap_q, snap_d;
  logic [WIDX_W-1:0] widx_q, widx_d;

  always_comb begin
    snap_d = snap_q;
    widx_d = widx_q;
    if (get_done) begin
      snap_d = PAD_W'(bits);
      widx_d = '0;
    end else if (pop && widx_q < WIDX_W'(NUM_WORDS)) begin
      widx_d = widx_q + 1'b1;
    end
    if (widx_q < WIDX_W'(NUM_WORDS)) word = snap_q[widx_q*32 +: 32];
    else                             word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      widx_q <= WIDX_W'(NUM_WORDS);
    end else begin
      if (get_done) snap_q <= snap_d;
      if (get_done || pop) widx_q <= widx_d;
    end
  end

endmodule

// File: rtl/cfgbit_ctrl.sv
module cfgbit_ctrl
  import cfgbit_pkg::*;
#(
  parameter logic [7:0] KEY         = 8'h5A,
  parameter int         NUM_BITS    = 3,
  parameter int         BUSY_CYCLES = 8,
  localparam int        IDX_W       = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                erase_pin,
  input  logic                erase_done,
  output logic                irq,
  output logic                lock,
  output logic                dbg_allow,
  output logic                fprog_allow,
  output logic [NUM_BITS-1:0] cfg_bits
);

  logic [1:0]       rsync_q;
  logic             rst_sync_n;
  logic             irq_en_q, irq_en_d;
  logic             key_ok, in_range;
  cmd_kind_t        kind;
  logic [IDX_W-1:0] bit_idx, do_idx;
  logic             ready_flag, err_flag;
  logic             do_set, do_clr, get_done;
  logic             cmd_wr, stat_rd, res_pop, mode_wr;
  logic [31:0]      res_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  assign cmd_wr  = bus_wr && (bus_addr == ADDR_CMD);
  assign mode_wr = bus_wr && (bus_addr == ADDR_MODE);
  assign stat_rd = bus_rd && (bus_addr == ADDR_STATUS);
  assign res_pop = bus_rd && (bus_addr == ADDR_RESULT);

  always_comb begin
    irq_en_d = irq_en_q;
    if (mode_wr) irq_en_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_en_q <= 1'b0;
    else if (mode_wr) irq_en_q <= irq_en_d;
  end

  cfgbit_cmd_decode #(.KEY(KEY), .NUM_BITS(NUM_BITS)) i_dec (
    .wdata   (bus_wdata),
    .key_ok  (key_ok),
    .kind    (kind),
    .in_range(in_range),
    .bit_idx (bit_idx)
  );

  cfgbit_seq #(.NUM_BITS(NUM_BITS), .BUSY_CYCLES(BUSY_CYCLES)) i_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd_wr  (cmd_wr),
    .key_ok  (key_ok),
    .kind    (kind),
    .in_range(in_range),
    .bit_idx (bit_idx),
    .stat_rd (stat_rd),
    .ready   (ready_flag),
    .err     (err_flag),
    .do_set  (do_set),
    .do_clr  (do_clr),
    .do_idx  (do_idx),
    .get_done(get_done)
  );

  cfgbit_store #(.NUM_BITS(NUM_BITS)) i_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .do_set    (do_set),
    .do_clr    (do_clr),
    .do_idx    (do_idx),
    .erase_pin (erase_pin),
    .erase_done(erase_done),
    .bits      (cfg_bits)
  );

  cfgbit_result #(.NUM_BITS(NUM_BITS)) i_res (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .get_done(get_done),
    .bits    (cfg_bits),
    .pop     (res_pop),
    .word    (res_word)
  );

  always_comb begin
    case (bus_addr)
      ADDR_MODE:   bus_rdata = {31'b0, irq_en_q};
      ADDR_STATUS: bus_rdata = {30'b0, err_flag, ready_flag};
      ADDR_RESULT: bus_rdata = res_word;
      default:     bus_rdata = '0;
    endcase
  end

  assign irq         = ready_flag && irq_en_q;
  assign lock        = cfg_bits[0];
  assign dbg_allow   = !cfg_bits[0];
  assign fprog_allow = !cfg_bits[0];

endmodule

// File: rtl/cfgbit_ctrl_chk.sv
module cfgbit_ctrl_chk #(
  parameter logic [7:0] KEY      = 8'h5A,
  parameter int         NUM_BITS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [1:0]          bus_addr,
  input logic [31:0]         bus_wdata,
  input logic                ready_flag,
  input logic                err_flag,
  input logic                erase_done,
  input logic                lock,
  input logic [NUM_BITS-1:0] cfg_bits
);

  logic cmd_wr, key_good, opc_good;
  assign cmd_wr   = bus_wr && (bus_addr == 2'd1);
  assign key_good = (bus_wdata[31:24] == KEY);
  assign opc_good = (bus_wdata[7:0] == 8'h01) || (bus_wdata[7:0] == 8'h02) ||
                    (bus_wdata[7:0] == 8'h03);

  // R2
  bad_key_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !key_good && ready_flag) |=> err_flag);

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && key_good && opc_good && ready_flag) |=> !ready_flag);

  // R9
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(erase_done));

  // R3
  bits_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits != $past(cfg_bits)) |-> ($rose(ready_flag) || $past(erase_done)));

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 2'd2) |=> !err_flag);

endmodule

bind cfgbit_ctrl cfgbit_ctrl_chk #(.KEY(KEY), .NUM_BITS(NUM_BITS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ready_flag(ready_flag),
  .err_flag  (err_flag),
  .erase_done(erase_done),
  .lock      (lock),
  .cfg_bits  (cfg_bits)
);

// File: tb/test_cfgbit_ctrl.sv
module test_cfgbit_ctrl;

  localparam int         CLK_PERIOD = 10;
  localparam int         NB         = 3;
  localparam int         BUSY       = 5;
  localparam logic [7:0] KEY        = 8'h5A;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr, bus_rd;
  logic [1:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          erase_pin, erase_done;
  logic          irq, lock, dbg_allow, fprog_allow;
  logic [NB-1:0] cfg_bits;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfgbit_ctrl #(.KEY(KEY), .NUM_BITS(NB), .BUSY_CYCLES(BUSY)) i_cfgbit_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .erase_pin(erase_pin), .erase_done(erase_done), .irq(irq), .lock(lock),
    .dbg_allow(dbg_allow), .fprog_allow(fprog_allow), .cfg_bits(cfg_bits)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input logic [7:0] k, input logic [15:0] a,
                                      input logic [7:0] o);
    return {k, a, o};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_ready(output int n);
    logic [31:0] s;
    n = 0;
    peek(2'd2, s);
    while (!s[0] && n < 1000) begin
      @(negedge clk);
      n++;
      peek(2'd2, s);
    end
  endtask

  task automatic t_reset;
    logic [31:0] s;
    peek(2'd2, s);
    check("R1 status", s, 32'h1);
    check("R1 bits", 32'(cfg_bits), 32'h0);
    check("R1 irq/lock/grants", {28'b0, irq, lock, dbg_allow, fprog_allow}, 32'h3);
    rd(2'd3, s);
    check("R12 result before get", s, 32'h0);
  endtask

  task automatic t_set_clear;
    int n;
    wr(2'd1, cmd(KEY, 16'd1, 8'h01));
    wait_ready(n);
    check("R5 set busy cycles", 32'(n), 32'(BUSY));
    check("R3 set bit1", 32'(cfg_bits), 32'h2);
    wr(2'd1, cmd(KEY, 16'd2, 8'h01));
    wait_ready(n);
    check("R3 set bit2", 32'(cfg_bits), 32'h6);
    wr(2'd1, cmd(KEY, 16'd1, 8'h02));
    wait_ready(n);
    check("R5 clear busy cycles", 32'(n), 32'(BUSY));
    check("R3 clear bit1", 32'(cfg_bits), 32'h4);
  endtask

  task automatic t_out_of_range;
    int n;
    wr(2'd1, cmd(KEY, 16'(NB), 8'h01));
    wait_ready(n);
    check("R4 set arg=NB completes", 32'(n), 32'(BUSY));
    check("R4 set arg=NB no change", 32'(cfg_bits), 32'h4);
    wr(2'd1, cmd(KEY, 16'hFF02, 8'h02));
    wait_ready(n);
    check("R4 clear big arg no change", 32'(cfg_bits), 32'h4);
  endtask

  task automatic t_bad_key;
    logic [31:0] s;
    wr(2'd1, cmd(8'hA5, 16'd0, 8'h01));
    peek(2'd2, s);
    check("R2 error set ready kept", s, 32'h3);
    check("R2 bits unchanged", 32'(cfg_bits), 32'h4);
    rd(2'd2, s);
    check("R10 read returns error", s, 32'h3);
    peek(2'd2, s);
    check("R10 error cleared", s, 32'h1);
    wr(2'd1, cmd(KEY, 16'd0, 8'h7E));
    peek(2'd2, s);
    check("R11 bad opcode error", s, 32'h3);
    check("R11 bits unchanged", 32'(cfg_bits), 32'h4);
    rd(2'd2, s);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] s;
    int n;
    wr(2'd1, cmd(KEY, 16'd1, 8'h01));
    wr(2'd1, cmd(KEY, 16'd2, 8'h02));
    wr(2'd1, cmd(8'h00, 16'd0, 8'h01));
    wait_ready(n);
    check("R5 busy writes ignored", 32'(cfg_bits), 32'h6);
    check("R5 busy count unchanged", 32'(n), 32'(BUSY - 2));
    peek(2'd2, s);
    check("R5 no error from busy write", s, 32'h1);
  endtask

  task automatic t_get;
    logic [31:0] s;
    int n;
    wr(2'd1, cmd(KEY, 16'h1234, 8'h03));
    wait_ready(n);
    check("R5 get busy one cycle", 32'(n), 32'h1);
    rd(2'd3, s);
    check("R7 first result word", s, 32'h6);
    rd(2'd3, s);
    check("R7 read past end", s, 32'h0);
    rd(2'd3, s);
    check("R7 second read past end", s, 32'h0);
  endtask

  task automatic t_irq;
    int n;
    check("R6 irq off when disabled", 32'(irq), 32'h0);
    wr(2'd0, 32'h1);
    check("R6 irq on when idle", 32'(irq), 32'h1);
    wr(2'd1, cmd(KEY, 16'd1, 8'h02));
    check("R6 irq low while busy", 32'(irq), 32'h0);
    wait_ready(n);
    check("R6 irq back at done", 32'(irq), 32'h1);
    wr(2'd0, 32'h0);
    check("R6 irq off again", 32'(irq), 32'h0);
  endtask

  task automatic t_security;
    int n;
    wr(2'd1, cmd(KEY, 16'd0, 8'h01));
    wait_ready(n);
    check("R8 locked", {29'b0, lock, dbg_allow, fprog_allow}, 32'h4);
    wr(2'd1, cmd(KEY, 16'd0, 8'h02));
    wait_ready(n);
    check("R8 clear cannot unlock", 32'(lock), 32'h1);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    check("R9 erase done alone no effect", 32'(lock), 32'h1);
    erase_pin = 1'b1;
    @(negedge clk);
    erase_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 pin alone no effect", 32'(lock), 32'h1);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    check("R9 erase unlocks", {29'b0, lock, dbg_allow, fprog_allow}, 32'h3);
    check("R9 other bits kept", 32'(cfg_bits), 32'h4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    erase_pin = 1'b0; erase_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_clear();
    t_out_of_range();
    t_bad_key();
    t_busy_ignore();
    t_get();
    t_irq();
    t_security();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule